// File: doc/BRIEF.md
# Programmable Synchronous Serial Frame Receiver

This block takes in one serial data line, advancing one bit each time a bit-clock enable is high. It slices the stream into frames. A frame opens either on an external start pulse or on an internal periodic timer. Each frame begins with a synchronisation window. The first bits of that window (up to 32 of them) are collected into a sync-data register, which is presented with a one-clock strobe when the window closes.

After a programmable delay, measured from the start event, the block assembles a programmable number of data words of programmable length. The first bit of each word goes in either the most or the least significant position of the word. Each finished word is right-justified onto a 32-bit output with a one-clock valid strobe. If a word completes before the previous one was acknowledged, a sticky overrun flag is raised.

Bits that fall between the sync window and the data start are discarded. Bits that arrive after the last data word and before the next frame are also discarded. When the delay is shorter than the sync window, the data bits come from inside the sync window. The configuration is expected to stay constant while a frame is in progress.

Top module: `sfr_rx`

## Requirements
- R1: The sync window lasts SL = cfg_sync_lo + 16*cfg_sync_hi + 1 ticks (a tick is a clock with bit_en high), counted from the start tick, which is frame index 0. One clock after the tick at index SL-1, sync_valid pulses for one clock. At that point sync_data holds the first min(SL,32) bits, with the earliest bit in the most significant of those positions and zeros above them.
- R2: The data bit with frame index D = cfg_delay is the first sampled data bit. When D > SL, the bits at indices SL to D-1 affect no output.
- R3: When D < SL, the sync bits at indices D and above are also taken in as data bits.
- R4: A frame delivers exactly N = cfg_words_m1+1 words (1 to 16) of W = cfg_wlen_m1+1 bits (1 to 32). Word k is built from the W consecutive data bits that follow the previous word.
- R5: With cfg_msb_first=1, the first bit of a word lands at bit W-1 and later bits go toward bit 0. With cfg_msb_first=0, the first bit lands at bit 0 and later bits go upward. Bits W to 31 of word_data are always zero.
- R6: word_valid is high for exactly the clock after the tick that completes a word. word_data holds that word until the next word completes.
- R7: overrun becomes 1 when a word completes while an earlier word has not been acknowledged by word_ack. Leaving word_ack high acknowledges every word. Once set, overrun stays at 1 until reset.
- R8: With cfg_period_en=1, a frame start is requested on the first tick after enabling and then every 2*(cfg_period+1) ticks. A request that arrives while a frame is in progress is dropped.
- R9: start_in high on a tick while no frame is active starts a frame on that tick. start_in during an active frame is ignored. frame_busy is high from the clock after the start tick until the clock after the frame's last tick, which is max(SL, D+N*W)-1. Bits after that tick affect no output.
- R10: rst_n low at a clock edge returns the block to idle. frame_busy, word_valid, sync_valid and overrun go to 0, and word_data and sync_data are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one serial bit per high cycle |
| sdin | input | 1 | Serial data line |
| start_in | input | 1 | External frame start request |
| cfg_sync_lo | input | 4 | Sync length, low part |
| cfg_sync_hi | input | 4 | Sync length, high part (weight 16) |
| cfg_delay | input | 8 | Ticks from start event to first data bit |
| cfg_wlen_m1 | input | 5 | Word length minus one |
| cfg_words_m1 | input | 4 | Words per frame minus one |
| cfg_msb_first | input | 1 | 1: first bit is the word's MSB |
| cfg_period | input | 9 | Periodic interval field (2*(value+1) ticks) |
| cfg_period_en | input | 1 | Enables the periodic start timer |
| word_ack | input | 1 | Consumer has taken the presented word |
| word_data | output | 32 | Last completed word, right-justified |
| word_valid | output | 1 | One-clock strobe for a new word |
| overrun | output | 1 | Sticky flag: word lost before acknowledge |
| sync_data | output | 32 | Captured sync bits |
| sync_valid | output | 1 | One-clock strobe at sync window end |
| frame_busy | output | 1 | A frame is in progress |

## Verification
The assertions assume that the configuration inputs do not change while frame_busy is high. They also assume that rst_n is low at the first clock edge. The zero-extension check on word_data compares against the cfg_wlen_m1 value that is current when word_valid is high, so it relies on that stability. The stimulus changes the configuration only after reset or after enough idle ticks for the frame to have ended. It also places its extra start pulses only inside frames that are known to be active.

// File: rtl/sfr_rx_pkg.sv
// Shared types for the serial frame receiver.
// Assumes: one strobe set is produced per clock by the sequencer.
package sfr_rx_pkg;

    // Per-clock strobes from the frame sequencer to the capture units
    typedef struct packed {
        logic frame_start;  // this tick opens a frame (index 0)
        logic sample_sync;  // this tick's bit enters the sync capture
        logic sync_last;    // this tick is the last sync-window bit
        logic sample_data;  // this tick's bit is a data bit
        logic word_last;    // this tick completes a word
    } seq_strobe_t;

endpackage

// File: rtl/sfr_rx_timer.sv
// Periodic frame-start request generator.
// Counts bit ticks and requests a start on count zero; the interval is
// 2*(period+1) ticks. Assumes period is stable while enabled.
module sfr_rx_timer #(
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             hit
);
    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    // last count value of the interval: 2*period+1
    assign last_cnt = {period, 1'b1};
    assign hit      = en && (cnt == '0);

    // tick counter, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (bit_en) begin
            cnt <= (cnt == last_cnt) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfr_rx_seq.sv
// Frame sequencer: tracks the position inside a frame and decides, tick by
// tick, whether a bit belongs to the sync window, to a data word, or to
// nothing. Assumes configuration is stable while a frame is active.
module sfr_rx_seq
    import sfr_rx_pkg::*;
#(
    parameter int IDX_W    = 9,
    parameter int DLY_W    = 8,
    parameter int WL_W     = 5,
    parameter int NW_W     = 4,
    parameter int SYNC_CAP = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             start_req,
    input  logic [IDX_W-1:0] sync_len,
    input  logic [DLY_W-1:0] delay,
    input  logic [WL_W-1:0]  wlen_m1,
    input  logic [NW_W-1:0]  nw_m1,
    output seq_strobe_t      stb,
    output logic [WL_W-1:0]  bit_pos,
    output logic             busy
);
    localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(1) << (IDX_W - 1);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [WL_W-1:0]  bcnt;
    logic [NW_W-1:0]  wcnt;
    logic             data_done, sync_done;

    logic             start_now, run;
    logic [IDX_W-1:0] c_idx;
    logic [WL_W-1:0]  c_b;
    logic [NW_W-1:0]  c_w;
    logic             c_dd, c_sd;
    logic             data_fin, sync_fin;

    // current-tick view: a starting frame sees cleared position state
    always_comb begin
        start_now = bit_en && !active && start_req;
        run       = bit_en && (active || start_now);
        c_idx     = active ? idx : '0;
        c_b       = active ? bcnt : '0;
        c_w       = active ? wcnt : '0;
        c_dd      = active && data_done;
        c_sd      = active && sync_done;

        stb.frame_start = start_now;
        stb.sample_sync = run && !c_sd && (c_idx < IDX_W'(SYNC_CAP));
        stb.sync_last   = run && !c_sd && (c_idx == sync_len - 1'b1);
        stb.sample_data = run && !c_dd && (c_idx >= IDX_W'(delay));
        stb.word_last   = stb.sample_data && (c_b == wlen_m1);
        data_fin        = c_dd || (stb.word_last && (c_w == nw_m1));
        sync_fin        = c_sd || stb.sync_last;
    end

    assign bit_pos = c_b;
    assign busy    = active;

    // position state advanced once per tick of an active frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            idx       <= '0;
            bcnt      <= '0;
            wcnt      <= '0;
            data_done <= 1'b0;
            sync_done <= 1'b0;
        end else if (run) begin
            active    <= !(data_fin && sync_fin);
            idx       <= (c_idx == IDX_SAT) ? c_idx : c_idx + 1'b1;
            bcnt      <= stb.word_last ? '0 : (stb.sample_data ? c_b + 1'b1 : c_b);
            wcnt      <= stb.word_last ? c_w + 1'b1 : c_w;
            data_done <= data_fin;
            sync_done <= sync_fin;
        end
    end
endmodule

// File: rtl/sfr_rx_deser.sv
// Word deserialiser: assembles data bits in either bit order, right-justified,
// presents each finished word with a one-clock strobe and tracks overrun.
// Assumes bit_pos counts from zero within each word.
module sfr_rx_deser #(
    parameter int WORD_W = 32,
    parameter int WL_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              word_last,
    input  logic [WL_W-1:0]   bit_pos,
    input  logic              msb_first,
    input  logic              sdin,
    input  logic              word_ack,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              overrun
);
    logic [WORD_W-1:0] acc, base, nxt;
    logic              pending;

    // next accumulator value for this bit
    always_comb begin
        base = (bit_pos == '0) ? '0 : acc;
        if (msb_first) nxt = {base[WORD_W-2:0], sdin};
        else           nxt = base | (WORD_W'(sdin) << bit_pos);
    end

    // accumulate, publish words, and track unacknowledged words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
            pending    <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (sample) acc <= nxt;
            if (word_last) begin
                word_data  <= nxt;
                word_valid <= 1'b1;
                pending    <= 1'b1;
                if (pending && !word_ack) overrun <= 1'b1;
            end else if (word_ack) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sfr_rx_synccap.sv
// Sync-data capture: shifts the leading sync-window bits into a register and
// publishes it when the window closes. Assumes the first sync bit arrives on
// the frame-start tick.
module sfr_rx_synccap #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sample,
    input  logic              last,
    input  logic              sdin,
    output logic [WORD_W-1:0] sync_data,
    output logic              sync_valid
);
    logic [WORD_W-1:0] sh, nxt;

    // shift value; a new frame starts from an empty register
    assign nxt = {(frame_start ? WORD_W'(0) : sh) << 1} | WORD_W'(sdin);

    // collect bits and publish at window end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            sync_data  <= '0;
            sync_valid <= 1'b0;
        end else begin
            sync_valid <= 1'b0;
            if (sample) sh <= nxt;
            if (last) begin
                sync_data  <= sample ? nxt : sh;
                sync_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfr_rx.sv
// Programmable serial frame receiver top. Combines the start sources,
// sequences each frame and feeds the word and sync capture units.
// Assumes configuration is held stable while frame_busy is high.
module sfr_rx
    import sfr_rx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SF_W   = 4,
    parameter int DLY_W  = 8,
    parameter int NW_W   = 4,
    parameter int PER_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              sdin,
    input  logic              start_in,
    input  logic [SF_W-1:0]   cfg_sync_lo,
    input  logic [SF_W-1:0]   cfg_sync_hi,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [$clog2(WORD_W)-1:0] cfg_wlen_m1,
    input  logic [NW_W-1:0]   cfg_words_m1,
    input  logic              cfg_msb_first,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              cfg_period_en,
    input  logic              word_ack,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              overrun,
    output logic [WORD_W-1:0] sync_data,
    output logic              sync_valid,
    output logic              frame_busy
);
    localparam int WL_W  = $clog2(WORD_W);
    localparam int IDX_W = 2 * SF_W + 1;

    logic             tmr_hit;
    logic [IDX_W-1:0] sync_len;
    logic [WL_W-1:0]  bit_pos;
    seq_strobe_t      stb;

    // sync window length: low field + 16 * high field + 1
    assign sync_len = IDX_W'({cfg_sync_hi, cfg_sync_lo}) + 1'b1;

    sfr_rx_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .en     (cfg_period_en),
        .period (cfg_period),
        .hit    (tmr_hit)
    );

    sfr_rx_seq #(
        .IDX_W(IDX_W), .DLY_W(DLY_W), .WL_W(WL_W), .NW_W(NW_W), .SYNC_CAP(WORD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .start_req (start_in || tmr_hit),
        .sync_len  (sync_len),
        .delay     (cfg_delay),
        .wlen_m1   (cfg_wlen_m1),
        .nw_m1     (cfg_words_m1),
        .stb       (stb),
        .bit_pos   (bit_pos),
        .busy      (frame_busy)
    );

    sfr_rx_deser #(.WORD_W(WORD_W), .WL_W(WL_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (stb.sample_data),
        .word_last  (stb.word_last),
        .bit_pos    (bit_pos),
        .msb_first  (cfg_msb_first),
        .sdin       (sdin),
        .word_ack   (word_ack),
        .word_data  (word_data),
        .word_valid (word_valid),
        .overrun    (overrun)
    );

    sfr_rx_synccap #(.WORD_W(WORD_W)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (stb.frame_start),
        .sample      (stb.sample_sync),
        .last        (stb.sync_last),
        .sdin        (sdin),
        .sync_data   (sync_data),
        .sync_valid  (sync_valid)
    );
endmodule

// File: rtl/sfr_rx_chk.sv
// Property checker for sfr_rx, bound to every instance of the top.
// Assumes configuration stable during frames and rst_n low at the first edge.
module sfr_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bit_en,
    input logic        start_in,
    input logic        cfg_period_en,
    input logic [4:0]  cfg_wlen_m1,
    input logic [31:0] word_data,
    input logic        word_valid,
    input logic        overrun,
    input logic        sync_valid,
    input logic        frame_busy
);
    // sync strobe only follows a bit tick
    assert_sync_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |-> $past(bit_en));

    // no bits above the configured word length
    assert_word_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (((word_data >> cfg_wlen_m1) >> 1) == 32'd0));

    // word strobe only follows a bit tick
    assert_valid_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(bit_en));

    // overrun never clears outside reset
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // a frame only opens with a start source present
    assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_busy) |-> $past(start_in || cfg_period_en));

    // reset leaves the block idle
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!frame_busy && !word_valid && !sync_valid && !overrun));
endmodule

bind sfr_rx sfr_rx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .start_in      (start_in),
    .cfg_period_en (cfg_period_en),
    .cfg_wlen_m1   (cfg_wlen_m1),
    .word_data     (word_data),
    .word_valid    (word_valid),
    .overrun       (overrun),
    .sync_valid    (sync_valid),
    .frame_busy    (frame_busy)
);

// File: tb/sfr_rx_tb.sv
// Testbench for sfr_rx: behavioural per-clock reference model plus directed
// scenario checks.
module sfr_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0, sdin = 1'b0, start_in = 1'b0, word_ack = 1'b1;
    logic [3:0]  cfg_sync_lo = '0, cfg_sync_hi = '0, cfg_words_m1 = '0;
    logic [7:0]  cfg_delay = '0;
    logic [4:0]  cfg_wlen_m1 = '0;
    logic        cfg_msb_first = 1'b1, cfg_period_en = 1'b0;
    logic [8:0]  cfg_period = '0;
    logic [31:0] word_data, sync_data;
    logic        word_valid, overrun, sync_valid, frame_busy;

    int checks = 0, errors = 0, cycles = 0;

    sfr_rx u_dut (.*);

    always #4 clk = ~clk;  // 125 MHz

    // ---------------- reference model ----------------
    int          pos = -1, tcnt = 0;
    bit          pending = 0, wcomp, hit;
    bit          sq[$];
    bit          wq[$];
    logic [31:0] e_wd = '0, e_sd = '0, v;
    bit          e_wv = 0, e_sv = 0, e_ov = 0, e_busy = 0;
    bit          model_on = 0;

    always @(posedge clk) begin
        int sl, d, w, n, last;
        e_wv = 0; e_sv = 0; wcomp = 0; hit = 0;
        if (!rst_n) begin
            pos = -1; tcnt = 0; pending = 0; e_ov = 0; e_wd = '0; e_sd = '0;
            e_busy = 0; sq.delete(); wq.delete();
        end else begin
            if (!cfg_period_en) tcnt = 0;
            else if (bit_en) begin
                hit = (tcnt == 0);
                tcnt = (tcnt + 1) % (2 * (int'(cfg_period) + 1));
            end
            if (bit_en) begin
                if (pos < 0 && (start_in || hit)) begin
                    pos = 0; sq.delete(); wq.delete();
                end
                if (pos >= 0) begin
                    sl = int'(cfg_sync_lo) + 16 * int'(cfg_sync_hi) + 1;
                    d  = int'(cfg_delay);
                    w  = int'(cfg_wlen_m1) + 1;
                    n  = int'(cfg_words_m1) + 1;
                    if (pos < sl && pos < 32) sq.push_back(sdin);
                    if (pos == sl - 1) begin
                        v = '0;
                        foreach (sq[i]) v = {v[30:0], sq[i]};
                        e_sd = v; e_sv = 1;
                    end
                    if (pos >= d && pos - d < n * w) begin
                        wq.push_back(sdin);
                        if (((pos - d) % w) == w - 1) begin
                            v = '0;
                            foreach (wq[i]) if (wq[i]) v[cfg_msb_first ? w - 1 - i : i] = 1'b1;
                            e_wd = v; e_wv = 1; wcomp = 1; wq.delete();
                        end
                    end
                    last = ((sl > d + n * w) ? sl : d + n * w) - 1;
                    if (pos == last) pos = -1; else pos++;
                end
            end
            if (wcomp) begin
                if (pending && !word_ack) e_ov = 1;
                pending = 1;
            end else if (word_ack) pending = 0;
            e_busy = (pos >= 0);
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (frame_busy !== e_busy) begin
                errors++; $display("FAIL R9 frame_busy act=%0b exp=%0b t=%0t", frame_busy, e_busy, $time);
            end
            if (word_valid !== e_wv) begin
                errors++; $display("FAIL R6 word_valid act=%0b exp=%0b t=%0t", word_valid, e_wv, $time);
            end
            if (word_data !== e_wd) begin
                errors++; $display("FAIL R5 word_data act=%h exp=%h t=%0t", word_data, e_wd, $time);
            end
            if (sync_valid !== e_sv) begin
                errors++; $display("FAIL R1 sync_valid act=%0b exp=%0b t=%0t", sync_valid, e_sv, $time);
            end
            if (sync_data !== e_sd) begin
                errors++; $display("FAIL R1 sync_data act=%h exp=%h t=%0t", sync_data, e_sd, $time);
            end
            if (overrun !== e_ov) begin
                errors++; $display("FAIL R7 overrun act=%0b exp=%0b t=%0t", overrun, e_ov, $time);
            end
        end
    end

    // ---------------- monitor ----------------
    int          nwords = 0, nsyncs = 0;
    logic [31:0] last_word = '0, last_sync = '0;
    always @(negedge clk) begin
        if (word_valid) begin last_word = word_data; nwords++; end
        if (sync_valid) begin last_sync = sync_data; nsyncs++; end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic set_cfg(input int lo, input int hi, input int dly, input int wl, input int nw,
                           input bit msb);
        cfg_sync_lo = 4'(lo); cfg_sync_hi = 4'(hi); cfg_delay = 8'(dly);
        cfg_wlen_m1 = 5'(wl); cfg_words_m1 = 4'(nw); cfg_msb_first = msb;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; start_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1; start_in = 1'b0; sdin = 1'b0;
        end
    endtask

    // random bits; start pulses at index 0 and at the listed indices
    task automatic run_rand(input int n, input int div, input int s1, input int s2);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en   = (i % div) == 0;
            sdin     = 1'($urandom % 2);
            start_in = (i == 0) || (i == s1) || (i == s2);
        end
        @(negedge clk);
        start_in = 1'b0; bit_en = 1'b0;
    endtask

    task automatic run_pat(input logic [63:0] pat, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1; sdin = pat[i]; start_in = (i == 0);
        end
        idle(8);
    endtask

    int w0, s0;

    initial begin
        do_reset();
        model_on = 1;
        @(posedge clk); #1;
        // R10: reset state
        chk(!frame_busy && !word_valid && !sync_valid && !overrun, "R10 idle after reset",
            {28'd0, frame_busy, word_valid, sync_valid, overrun}, 32'd0);
        chk(word_data == 0 && sync_data == 0, "R10 cleared data", word_data | sync_data, 32'd0);

        // R4/R9: MSB first, gap after sync, slow tick, extra starts inside the frame
        set_cfg(3, 0, 6, 7, 1, 1);
        @(posedge clk); #1; w0 = nwords;
        run_rand(100, 3, 9, 30);
        idle(10);
        @(posedge clk); #1;
        chk(nwords - w0 == 2, "R4 R9 words per frame with ignored starts", nwords - w0, 2);
        chk(overrun == 0, "R7 no overrun while acknowledged", overrun, 0);

        // R3: LSB first, delay inside the sync window
        set_cfg(3, 0, 2, 4, 2, 0);
        @(posedge clk); #1; w0 = nwords;
        run_rand(40, 1, -1, -1);
        idle(10);
        @(posedge clk); #1;
        chk(nwords - w0 == 3, "R4 R3 three words with overlap", nwords - w0, 3);

        // R1: long sync window, 32-bit word
        set_cfg(7, 2, 45, 31, 0, 1);
        @(posedge clk); #1; w0 = nwords; s0 = nsyncs;
        run_rand(180, 2, -1, -1);
        idle(10);
        @(posedge clk); #1;
        chk(nsyncs - s0 == 1, "R1 one sync capture", nsyncs - s0, 1);
        chk(nwords - w0 == 1, "R4 one 32-bit word", nwords - w0, 1);

        // R2: gap bits ignored, MSB first -> 1010
        set_cfg(1, 0, 6, 3, 0, 1);
        run_pat(64'h17F, 12);
        @(posedge clk); #1;
        chk(last_word == 32'hA, "R2 gap ignored msb word", last_word, 32'hA);
        chk(last_sync == 32'h3, "R1 short sync value", last_sync, 32'h3);
        // R5: same stream LSB first -> 0101
        set_cfg(1, 0, 6, 3, 0, 0);
        run_pat(64'h17F, 12);
        @(posedge clk); #1;
        chk(last_word == 32'h5, "R5 lsb word order", last_word, 32'h5);

        // R3: sync bits 3..6 reused as data, LSB first
        set_cfg(7, 0, 3, 3, 0, 0);
        run_pat(64'h98, 12);
        @(posedge clk); #1;
        chk(last_word == 32'h3, "R3 sync bits as data", last_word, 32'h3);
        chk(last_sync == 32'h19, "R1 eight-bit sync value", last_sync, 32'h19);

        // R8: periodic starts every 42 ticks
        do_reset();
        set_cfg(0, 0, 1, 3, 2, 1);
        cfg_period = 9'd20;
        @(posedge clk); #1; s0 = nsyncs;
        @(negedge clk); cfg_period_en = 1'b1;
        for (int i = 0; i < 140; i++) begin
            bit_en = 1'b1; sdin = 1'($urandom % 2); start_in = 1'b0;
            @(negedge clk);
        end
        cfg_period_en = 1'b0; bit_en = 1'b0;
        idle(20);
        @(posedge clk); #1;
        chk(nsyncs - s0 == 4, "R8 periodic frame count", nsyncs - s0, 4);

        // R7: overrun when words are not acknowledged
        do_reset();
        set_cfg(0, 0, 0, 0, 3, 1);
        word_ack = 1'b0;
        run_rand(20, 1, -1, -1);
        idle(4);
        @(posedge clk); #1;
        chk(overrun == 1, "R7 overrun set", overrun, 1);
        idle(6);
        @(posedge clk); #1;
        chk(overrun == 1, "R7 overrun sticky", overrun, 1);
        word_ack = 1'b1;

        // R10: reset in the middle of a frame
        set_cfg(15, 3, 100, 31, 15, 1);
        @(negedge clk); bit_en = 1'b1; start_in = 1'b1; sdin = 1'b1;
        @(negedge clk); start_in = 1'b0;
        idle(5);
        @(posedge clk); #1;
        chk(frame_busy == 1, "R9 busy during frame", frame_busy, 1);
        do_reset();
        @(posedge clk); #1;
        chk(!frame_busy && !overrun && sync_data == 0, "R10 mid-frame reset to idle",
            {30'd0, frame_busy, overrun}, 32'd0);

        idle(5);
        model_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule